// File: doc/BRIEF.md
# Paired-Channel Masked Interrupt Controller

This block gathers the interrupt-worthy events of two serial channels (labelled A and B) plus four general-purpose input pins into one 8-bit event status word. A mask register selects which of those bits may pull the active-low interrupt line. A CPU reaches the block through a small register file driven by single-cycle read and write strobes. Reads are combinational in the strobe cycle.

Each input pin passes through a two-stage synchroniser and then a persistence filter. A new level is accepted only when it has been seen on consecutive synchronised samples. Each accepted change latches a per-pin flag. The flags are cleared by reading the input-change register. A change accepted in the same cycle as that read is kept for the next read.

Each channel has a break-change tracker. It latches any edge of the channel's break-detect level and holds it until the CPU issues a clear command. The receive event of each channel is either "receiver ready" or "FIFO full", chosen by a configuration bit.

Register map (3-bit address):

| Address | Access | Contents |
|---|---|---|
| 0 | read | event status word |
| 1 | read/write | interrupt mask |
| 2 | read, clears flags | input-change register |
| 3 | read | pin levels |
| 4 | write only | break-change clear command |
| 5 | read/write | receive-event source select |

State machines:

- **Pin filter** (one per pin). States are `FLT_STEADY` and `FLT_PENDING`.
  - `FLT_STEADY` moves to `FLT_PENDING` when the synchronised level differs from the accepted level.
  - `FLT_PENDING` returns to `FLT_STEADY` when the level falls back to the accepted value; this is glitch rejection.
  - `FLT_PENDING` also returns to `FLT_STEADY` when the mismatch has lasted PERSIST samples. In that case it accepts the new level and emits a one-cycle change pulse.
- **Break tracker** (one per channel). States are `BRK_IDLE` and `BRK_FLAGGED`.
  - `BRK_IDLE` moves to `BRK_FLAGGED` on any edge of the break level.
  - `BRK_FLAGGED` returns to `BRK_IDLE` on a clear command, but only when no edge arrives in the same cycle.

Top module: `pair_irq_ctrl`

## Requirements
- R1: After reset the mask, the source select, all change flags and both break-change bits are 0, the accepted pin levels are 0, and `irq_n` is 1.
- R2: `irq_n` is 0 exactly when some bit of the event status word is 1 and the mask bit at the same position (mask at address 1) is 1. Unmasked status bits never affect `irq_n`.
- R3: The event status word at address 0 has this layout: bit0 = A transmit ready, bit1 = A receive event, bit2 = A break change, bit3 = 0, bit4 = B transmit ready, bit5 = B receive event, bit6 = B break change, bit7 = any pin change flag set. Event inputs appear one clock after they are sampled. Reading it returns these bits whatever the mask holds.
- R4: Bit0 of address 5 selects `fifo_full_a` as A's receive event, and bit1 selects `fifo_full_b` for B. A 0 selects the receiver-ready input. Reads of address 5 return zeros in bits 7:2.
- R5: A rising or a falling edge of a channel's break input sets that channel's break-change bit. The bit stays set until a write to address 4 with data bit0 (A) or bit1 (B) set. An edge in the same cycle as the clear leaves the bit set.
- R6: A pin change is flagged only after the synchronised level has differed from the accepted level on 2 consecutive samples. A pin held for a single clock is never flagged. A level applied before clock edge k is flagged after edge k+3.
- R7: Address 2 reads pin change flags in bits 7:4 (pin i in bit 4+i) and synchronised pin levels in bits 3:0. A read of address 2 clears all change flags and thus status bit 7.
- R8: A change accepted in the very cycle of a read of address 2 is not lost. It remains flagged after that read.
- R9: Address 3 returns the synchronised pin levels in bits 3:0 and zero above. Reading it clears nothing.
- R10: The mask reads back as written. Addresses 4, 6 and 7 read as 0. Writes to addresses 0, 2, 3, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_rdy_a | input | 1 | Channel A transmit-ready level |
| rx_rdy_a | input | 1 | Channel A receiver-ready level |
| fifo_full_a | input | 1 | Channel A receive FIFO full level |
| break_a | input | 1 | Channel A break-detect level |
| tx_rdy_b | input | 1 | Channel B transmit-ready level |
| rx_rdy_b | input | 1 | Channel B receiver-ready level |
| fifo_full_b | input | 1 | Channel B receive FIFO full level |
| break_b | input | 1 | Channel B break-detect level |
| gp_pin | input | 4 | Asynchronous general-purpose input pins |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the strobe cycle |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench sweeps the read of the change register across every cycle offset from a pin toggle. Exactly one offset makes the accepted change land in the read cycle. A design that clears unconditionally on read would drop that change and show a zero flag on the second read.

One-clock pin pulses check the persistence filter. A filter that accepts on a single sample would raise status bit 7.

A break edge issued together with its clear command checks the set-wins rule. The bench also programs a mask that hides set status bits. A design that masked the status read, or leaked unmasked bits onto `irq_n`, would disagree with the per-cycle reference model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int PIN_W  = 4;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        RA_STATUS = 3'd0,
        RA_MASK   = 3'd1,
        RA_CHANGE = 3'd2,
        RA_LEVEL  = 3'd3,
        RA_CMD    = 3'd4,
        RA_SRCSEL = 3'd5
    } reg_addr_e;

    typedef enum logic {
        FLT_STEADY  = 1'b0,
        FLT_PENDING = 1'b1
    } flt_state_e;

    typedef enum logic {
        BRK_IDLE    = 1'b0,
        BRK_FLAGGED = 1'b1
    } brk_state_e;

endpackage

// File: rtl/irqc_pin_filter.sv
module irqc_pin_filter
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PERSIST     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic change_o
);
    localparam int CNT_W = $clog2(PERSIST + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERSIST - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level;
    logic                   accepted_q, accepted_d;
    logic [CNT_W-1:0]       run_q, run_d;
    flt_state_e             state_q, state_d;
    logic                   mismatch;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_i;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            end
        end
    endgenerate

    assign level    = sync_q[SYNC_STAGES-1];
    assign mismatch = (level != accepted_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= FLT_STEADY;
            run_q      <= '0;
            accepted_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            run_q      <= run_d;
            accepted_q <= accepted_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        run_d      = run_q;
        accepted_d = accepted_q;
        change_o   = 1'b0;
        unique case (state_q)
            FLT_STEADY: begin
                if (mismatch) begin
                    state_d = FLT_PENDING;
                    run_d   = CNT_W'(1);
                end
            end
            FLT_PENDING: begin
                if (!mismatch) begin
                    state_d = FLT_STEADY;
                    run_d   = '0;
                end else if (run_q == LAST_CNT) begin
                    change_o   = 1'b1;
                    accepted_d = level;
                    state_d    = FLT_STEADY;
                    run_d      = '0;
                end else begin
                    run_d = run_q + CNT_W'(1);
                end
            end
            default: state_d = FLT_STEADY;
        endcase
    end

    assign level_o = level;

    // A level is accepted only after it has been held over consecutive samples
    assert_change_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        change_o |-> (level == $past(level)));

    // A one-sample mismatch never produces a change pulse
    assert_no_single_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLT_STEADY) |-> !change_o);

endmodule

// File: rtl/irqc_brk_track.sv
module irqc_brk_track
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic brk_i,
    input  logic clr_i,
    output logic chg_o
);
    brk_state_e state_q, state_d;
    logic       prev_q;
    logic       edge_seen;

    assign edge_seen = (brk_i != prev_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BRK_IDLE;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= brk_i;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BRK_IDLE:    if (edge_seen)            state_d = BRK_FLAGGED;
            BRK_FLAGGED: if (clr_i && !edge_seen)  state_d = BRK_IDLE;
            default:                               state_d = BRK_IDLE;
        endcase
    end

    // Output
    always_comb begin
        chg_o = (state_q == BRK_FLAGGED);
    end

    assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> chg_o);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_o && !clr_i) |=> chg_o);

endmodule

// File: rtl/pair_irq_ctrl.sv
module pair_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PERSIST     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_rdy_a,
    input  logic                rx_rdy_a,
    input  logic                fifo_full_a,
    input  logic                break_a,
    input  logic                tx_rdy_b,
    input  logic                rx_rdy_b,
    input  logic                fifo_full_b,
    input  logic                break_b,
    input  logic [PIN_W-1:0]    gp_pin,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq_n
);
    localparam int NCH = 2;

    logic [PIN_W-1:0]  pin_level;
    logic [PIN_W-1:0]  pin_change;
    logic [PIN_W-1:0]  flags_q;
    logic [DATA_W-1:0] mask_q;
    logic [NCH-1:0]    srcsel_q;
    logic [NCH-1:0]    tx_q, rxr_q, ffl_q;
    logic [NCH-1:0]    brk_in, brk_clr, brk_chg;
    logic [NCH-1:0]    rx_evt;
    logic [DATA_W-1:0] status;
    logic              rd_change;
    logic              wr_cmd;

    assign rd_change = reg_rd && (reg_addr == RA_CHANGE);
    assign wr_cmd    = reg_wr && (reg_addr == RA_CMD);
    assign brk_in    = {break_b, break_a};
    assign brk_clr   = {NCH{wr_cmd}} & reg_wdata[NCH-1:0];

    generate
        for (genvar p = 0; p < PIN_W; p++) begin : g_pin
            irqc_pin_filter #(
                .SYNC_STAGES(SYNC_STAGES),
                .PERSIST    (PERSIST)
            ) u_flt (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_i   (gp_pin[p]),
                .level_o (pin_level[p]),
                .change_o(pin_change[p])
            );
        end
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            irqc_brk_track u_brk (
                .clk  (clk),
                .rst_n(rst_n),
                .brk_i(brk_in[c]),
                .clr_i(brk_clr[c]),
                .chg_o(brk_chg[c])
            );
            assign rx_evt[c] = srcsel_q[c] ? ffl_q[c] : rxr_q[c];
        end
    endgenerate

    // Event level capture, registers and change flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q     <= '0;
            rxr_q    <= '0;
            ffl_q    <= '0;
            mask_q   <= '0;
            srcsel_q <= '0;
            flags_q  <= '0;
        end else begin
            tx_q  <= {tx_rdy_b, tx_rdy_a};
            rxr_q <= {rx_rdy_b, rx_rdy_a};
            ffl_q <= {fifo_full_b, fifo_full_a};
            if (reg_wr && reg_addr == RA_MASK)   mask_q   <= reg_wdata;
            if (reg_wr && reg_addr == RA_SRCSEL) srcsel_q <= reg_wdata[NCH-1:0];
            flags_q <= (rd_change ? '0 : flags_q) | pin_change;
        end
    end

    assign status = {|flags_q, brk_chg[1], rx_evt[1], tx_q[1],
                     1'b0,     brk_chg[0], rx_evt[0], tx_q[0]};

    always_comb begin
        irq_n = ~|(status & mask_q);
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_STATUS: reg_rdata = status;
            RA_MASK:   reg_rdata = mask_q;
            RA_CHANGE: reg_rdata = {flags_q, pin_level};
            RA_LEVEL:  reg_rdata = {{(DATA_W-PIN_W){1'b0}}, pin_level};
            RA_SRCSEL: reg_rdata = {{(DATA_W-NCH){1'b0}}, srcsel_q};
            default:   reg_rdata = '0;
        endcase
    end

    assert_mask_zero_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> irq_n);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_change && pin_change == '0) |=> (flags_q == '0));

    assert_change_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_change && pin_change != '0) |=> (flags_q != '0));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > RA_SRCSEL || reg_addr == RA_CMD) |-> (reg_rdata == '0));

    assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_change && flags_q != '0) |=> (flags_q != '0));

endmodule

// File: tb/sim_pair_irq_ctrl.sv
module sim_pair_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txa = 0, rxa = 0, ffa = 0, brka = 0;
    logic txb = 0, rxb = 0, ffb = 0, brkb = 0;
    logic [3:0] pins = '0;
    logic [2:0] addr = '0;
    logic wr = 0, rd = 0;
    logic [7:0] wd = '0;
    logic [7:0] rdata;
    logic irq_n;
    int tests = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pair_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_rdy_a(txa), .rx_rdy_a(rxa), .fifo_full_a(ffa), .break_a(brka),
        .tx_rdy_b(txb), .rx_rdy_b(rxb), .fifo_full_b(ffb), .break_b(brkb),
        .gp_pin(pins), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
        .reg_wdata(wd), .reg_rdata(rdata), .irq_n(irq_n)
    );

    // Behavioural reference model
    logic [3:0] m_s1, m_s2, m_acc, m_flags;
    int         m_run [4];
    logic [1:0] m_bprev, m_bchg, m_tx, m_rx, m_ff, m_sel;
    logic [7:0] m_mask;

    function automatic logic [7:0] m_status();
        logic rxe_a, rxe_b;
        rxe_a = m_sel[0] ? m_ff[0] : m_rx[0];
        rxe_b = m_sel[1] ? m_ff[1] : m_rx[1];
        return {|m_flags, m_bchg[1], rxe_b, m_tx[1], 1'b0, m_bchg[0], rxe_a, m_tx[0]};
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0:    return m_status();
            3'd1:    return m_mask;
            3'd2:    return {m_flags, m_s2};
            3'd3:    return {4'h0, m_s2};
            3'd5:    return {6'b0, m_sel};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_acc = '0; m_flags = '0;
            for (int i = 0; i < 4; i++) m_run[i] = 0;
            m_bprev = '0; m_bchg = '0; m_tx = '0; m_rx = '0; m_ff = '0;
            m_sel = '0; m_mask = '0;
        end else begin
            logic [3:0] pulse;
            logic [1:0] bin, clr;
            pulse = '0;
            for (int i = 0; i < 4; i++) begin
                if (m_s2[i] != m_acc[i]) m_run[i]++;
                else m_run[i] = 0;
                if (m_run[i] == 2) begin
                    pulse[i] = 1'b1;
                    m_acc[i] = m_s2[i];
                    m_run[i] = 0;
                end
            end
            m_flags = ((rd && addr == 3'd2) ? 4'h0 : m_flags) | pulse;
            m_s2 = m_s1;
            m_s1 = pins;
            bin = {brkb, brka};
            clr = (wr && addr == 3'd4) ? wd[1:0] : 2'b00;
            for (int c = 0; c < 2; c++) begin
                if (bin[c] != m_bprev[c]) m_bchg[c] = 1'b1;
                else if (clr[c]) m_bchg[c] = 1'b0;
            end
            m_bprev = bin;
            if (wr && addr == 3'd1) m_mask = wd;
            if (wr && addr == 3'd5) m_sel = wd[1:0];
            m_tx = {txb, txa}; m_rx = {rxb, rxa}; m_ff = {ffb, ffa};
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle interrupt comparison (R2)
    always @(negedge clk) begin
        if (rst_n) begin
            #3;
            chk("R2 irq_n", {7'b0, irq_n}, {7'b0, ~|(m_status() & m_mask)});
        end
    end

    task automatic rd_reg(input logic [2:0] a, input string tag);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #2;
        chk(tag, rdata, m_read(a));
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wd = d; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq_n in reset", {7'b0, irq_n}, 8'h01);
        rst_n = 1'b1;
        idle(2);
        rd_reg(3'd0, "R1 status");
        rd_reg(3'd1, "R1 mask");
        rd_reg(3'd2, "R1 change");
        rd_reg(3'd5, "R1 srcsel");

        // R2/R3: unmasked status visible, no interrupt
        @(negedge clk); txa = 1; txb = 1;
        idle(2);
        rd_reg(3'd0, "R3 tx bits with mask 0");
        wr_reg(3'd1, 8'h01);
        rd_reg(3'd1, "R10 mask readback");
        idle(2);
        chk("R2 masked tx A asserts", {7'b0, irq_n}, 8'h00);
        @(negedge clk); txa = 0;
        idle(2);
        rd_reg(3'd0, "R3 tx B only");

        // R4: receive source select
        @(negedge clk); rxa = 1; ffb = 1;
        idle(2);
        rd_reg(3'd0, "R4 rx ready A selected");
        wr_reg(3'd5, 8'hFF);
        rd_reg(3'd5, "R4 srcsel upper zero");
        rd_reg(3'd0, "R4 fifo full selected");
        wr_reg(3'd1, 8'h22);
        idle(2);
        @(negedge clk); rxa = 0; ffb = 0;
        idle(2);

        // R5: break change
        wr_reg(3'd1, 8'h44);
        @(negedge clk); brka = 1;
        idle(2);
        rd_reg(3'd0, "R5 break A rise");
        @(negedge clk); brka = 0;
        idle(2);
        rd_reg(3'd0, "R5 break A fall still set");
        wr_reg(3'd4, 8'h01);
        rd_reg(3'd0, "R5 break A cleared");
        @(negedge clk); brkb = 1;
        idle(2);
        @(negedge clk); addr = 3'd4; wd = 8'h02; wr = 1; brkb = 0;
        @(posedge clk); #1; wr = 0;
        rd_reg(3'd0, "R5 edge with clear keeps bit");
        wr_reg(3'd4, 8'h02);
        rd_reg(3'd0, "R5 break B cleared");

        // R6: glitch rejection and latency
        wr_reg(3'd1, 8'h80);
        @(negedge clk); pins[0] = 1;
        @(negedge clk); pins[0] = 0;
        idle(6);
        rd_reg(3'd0, "R6 one-clock glitch ignored");
        @(negedge clk); pins[1] = 1;
        idle(3);
        #2 chk("R6 not yet flagged", {7'b0, irq_n}, 8'h01);
        idle(2);
        rd_reg(3'd0, "R6 change flagged");

        // R7/R9: change and level registers
        rd_reg(3'd3, "R9 level read");
        rd_reg(3'd0, "R9 level read clears nothing");
        rd_reg(3'd2, "R7 change register");
        rd_reg(3'd2, "R7 flags cleared");
        rd_reg(3'd0, "R7 status bit7 cleared");

        // R8: sweep read position against accepted change
        for (int k = 0; k < 7; k++) begin
            @(negedge clk); pins[2] = ~pins[2];
            idle(k);
            rd_reg(3'd2, "R8 read near change");
            rd_reg(3'd2, "R8 second read");
            rd_reg(3'd0, "R8 status after reads");
            idle(5);
            rd_reg(3'd2, "R8 drain");
        end

        // R10: unmapped reads, writes to read-only addresses
        wr_reg(3'd0, 8'hFF);
        wr_reg(3'd2, 8'hFF);
        wr_reg(3'd3, 8'hFF);
        wr_reg(3'd6, 8'hFF);
        wr_reg(3'd7, 8'hFF);
        rd_reg(3'd4, "R10 command reads zero");
        rd_reg(3'd6, "R10 addr 6 zero");
        rd_reg(3'd7, "R10 addr 7 zero");
        rd_reg(3'd1, "R10 mask untouched");
        rd_reg(3'd5, "R10 srcsel untouched");
        rd_reg(3'd0, "R10 status untouched");

        idle(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule